// File: doc/BRIEF.md
# Local-Bus Pass-Through Transfer Sequencer

This block sits on the bridge side of a pass-through path. A host-side agent hands it a pending request: address, direction, byte enables, burst flag, a two-bit region number and a beat count. The block raises an active-low attention line toward local logic. It waits until that attention is qualified by the local wait input. It then runs the data phase on a shared 32-bit local data bus. Each region has a small control field that selects an optional address-presentation cycle and a wait-state count.

For writes the block drives host-supplied data on every strobed cycle and pulses an advance signal so that the host can present the next word. For reads it captures the bus on every strobed edge and hands the word back with a valid pulse. When the last beat has gone, attention is released and a one-cycle done pulse is raised. The data bus is modelled as separate drive, enable and receive ports, so the pad tri-state sits outside the block.

Top module: `ptx_seq`

## Requirements
- R1: While reset is held and after it is released, the block is idle. In that state lb_attn_n, lb_addr_n, lb_xfer_n and lb_burst_n are 1, lb_be_n is 4'hF, lb_dq_oe, done and rd_valid are 0.
- R2: A req_start seen in idle drives lb_attn_n low from the next cycle. lb_attn_n stays low through the cycle of the last strobe. A req_start seen while a transfer is in progress has no effect.
- R3: Attention counts as valid only at a rising edge where lb_attn_n is low and lb_wait_n is 1. Before that edge, neither the address strobe nor the transfer strobe is asserted.
- R4: Region r owns bits [4r+3:4r] of region_cfg, and bit 3 of that field enables the address phase. When the bit is 1, lb_addr_n is low for exactly the one cycle after attention becomes valid. When it is 0, lb_addr_n never goes low for that transfer.
- R5: While lb_addr_n is low, lb_dq_oe is 1 and lb_dq_o carries the address latched at acceptance, whatever happens on req_addr later.
- R6: For a read with the address phase enabled and a wait-state field of 0, the cycle after the address cycle is a turnaround: lb_dq_oe is 0 and lb_xfer_n is 1. The first strobe comes in the following cycle.
- R7: With the address phase disabled and zero wait states, the first lb_xfer_n low cycle is the one right after attention becomes valid, for both reads and writes.
- R8: Bits [2:0] of the region field give a wait count W (0 to 7). W idle cycles precede every strobe, counted from the valid attention edge or from the address cycle. Consecutive strobes are therefore W+1 cycles apart.
- R9: During a write strobe, lb_dq_oe is 1, lb_dq_o equals wr_data and wr_next is 1.
- R10: During reads the block never drives the bus. rd_valid pulses in the cycle after each read strobe, with rd_data holding lb_dq_i as sampled at that strobe's closing edge.
- R11: A burst request with a non-zero req_beats makes that many strobes. A burst with req_beats of 0, or a non-burst request, makes one strobe. After the last strobe, lb_attn_n returns to 1 and done is 1 for exactly one cycle.
- R12: While attention is low, lb_write, lb_be_n (active low, 4'h0 meaning all bytes), lb_region and lb_burst_n reflect the request as accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request pending, accepted when idle |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be_n | input | 4 | Active-low byte enables |
| req_burst | input | 1 | Burst request |
| req_region | input | 2 | Region number |
| req_beats | input | 8 | Beat count for bursts |
| region_cfg | input | 16 | Per-region field: bit 3 address phase, bits 2:0 wait states |
| wr_data | input | 32 | Write word for the current beat |
| wr_next | output | 1 | Current write word is being strobed |
| rd_data | output | 32 | Captured read word |
| rd_valid | output | 1 | rd_data is new |
| done | output | 1 | One-cycle completion pulse |
| lb_attn_n | output | 1 | Active-low attention to local logic |
| lb_wait_n | input | 1 | Active-low wait from local logic |
| lb_addr_n | output | 1 | Active-low address strobe |
| lb_xfer_n | output | 1 | Active-low transfer strobe |
| lb_write | output | 1 | Direction of the current transfer |
| lb_burst_n | output | 1 | Active-low burst indication |
| lb_region | output | 2 | Region of the current transfer |
| lb_be_n | output | 4 | Active-low byte enables |
| lb_dq_o | output | 32 | Data bus drive value |
| lb_dq_oe | output | 1 | Data bus drive enable |
| lb_dq_i | input | 32 | Data bus receive value |

## Verification
The properties assume that local logic keeps to the pass-through protocol. They also assume that region_cfg stays steady while a transfer runs, since the turnaround property reads the direction from the outputs rather than from the configuration. The stimulus loads region_cfg before each req_start and changes it only in idle. lb_wait_n is moved only while attention is pending, so its effect shows up solely in when attention becomes valid. Read data is changed only after its capturing edge has passed.

// File: rtl/ptx_seq.sv
module ptx_seq #(
  parameter int DW     = 32,
  parameter int NREG   = 4,
  parameter int WS_W   = 3,
  parameter int BEAT_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_start,
  input  logic [DW-1:0]               req_addr,
  input  logic                        req_write,
  input  logic [DW/8-1:0]             req_be_n,
  input  logic                        req_burst,
  input  logic [$clog2(NREG)-1:0]     req_region,
  input  logic [BEAT_W-1:0]           req_beats,
  input  logic [NREG*(WS_W+1)-1:0]    region_cfg,
  input  logic [DW-1:0]               wr_data,
  output logic                        wr_next,
  output logic [DW-1:0]               rd_data,
  output logic                        rd_valid,
  output logic                        done,
  output logic                        lb_attn_n,
  input  logic                        lb_wait_n,
  output logic                        lb_addr_n,
  output logic                        lb_xfer_n,
  output logic                        lb_write,
  output logic                        lb_burst_n,
  output logic [$clog2(NREG)-1:0]     lb_region,
  output logic [DW/8-1:0]             lb_be_n,
  output logic [DW-1:0]               lb_dq_o,
  output logic                        lb_dq_oe,
  input  logic [DW-1:0]               lb_dq_i
);
  localparam int RW = $clog2(NREG);
  localparam int CW = WS_W + 1;
  localparam int BW = DW / 8;

  typedef enum logic [2:0] {S_IDLE, S_ATTN, S_ADDR, S_TURN, S_GAP, S_XFER} st_t;

  st_t             st;
  logic [DW-1:0]   addr_q;
  logic            wr_q, burst_q, en_q;
  logic [BW-1:0]   be_q;
  logic [RW-1:0]   rg_q;
  logic [WS_W-1:0] ws_q, gap_q;
  logic [BEAT_W-1:0] left_q;
  logic [CW-1:0]   cfg_sel;
  st_t             data_nx;

  assign cfg_sel = region_cfg[req_region*CW +: CW];
  assign data_nx = (ws_q == '0) ? S_XFER : S_GAP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      wr_q     <= 1'b0;
      burst_q  <= 1'b0;
      en_q     <= 1'b0;
      be_q     <= '1;
      rg_q     <= '0;
      ws_q     <= '0;
      gap_q    <= '0;
      left_q   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      case (st)
        S_IDLE: if (req_start) begin
          addr_q  <= req_addr;
          wr_q    <= req_write;
          burst_q <= req_burst;
          be_q    <= req_be_n;
          rg_q    <= req_region;
          en_q    <= cfg_sel[CW-1];
          ws_q    <= cfg_sel[WS_W-1:0];
          left_q  <= (req_burst && req_beats != '0) ? req_beats : BEAT_W'(1);
          st      <= S_ATTN;
        end
        S_ATTN: if (lb_wait_n) begin
          if (en_q) st <= S_ADDR;
          else begin
            st    <= data_nx;
            gap_q <= ws_q;
          end
        end
        S_ADDR: begin
          if (!wr_q && ws_q == '0) st <= S_TURN;
          else begin
            st    <= data_nx;
            gap_q <= ws_q;
          end
        end
        S_TURN: st <= S_XFER;
        S_GAP: begin
          if (gap_q == WS_W'(1)) st <= S_XFER;
          gap_q <= gap_q - 1'b1;
        end
        S_XFER: begin
          if (!wr_q) begin
            rd_valid <= 1'b1;
            rd_data  <= lb_dq_i;
          end
          if (left_q == BEAT_W'(1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            left_q <= left_q - 1'b1;
            st     <= data_nx;
            gap_q  <= ws_q;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic busy;
  assign busy       = (st != S_IDLE);
  assign lb_attn_n  = !busy;
  assign lb_addr_n  = (st != S_ADDR);
  assign lb_xfer_n  = (st != S_XFER);
  assign lb_write   = busy && wr_q;
  assign lb_burst_n = !(busy && burst_q);
  assign lb_region  = busy ? rg_q : '0;
  assign lb_be_n    = busy ? be_q : '1;
  assign wr_next    = (st == S_XFER) && wr_q;
  assign lb_dq_oe   = (st == S_ADDR) || wr_next;
  assign lb_dq_o    = (st == S_ADDR) ? addr_q : (wr_next ? wr_data : '0);
endmodule

// File: rtl/ptx_seq_chk.sv
module ptx_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic lb_attn_n,
  input logic lb_wait_n,
  input logic lb_addr_n,
  input logic lb_xfer_n,
  input logic lb_dq_oe,
  input logic lb_write,
  input logic wr_next,
  input logic rd_valid,
  input logic done
);
  a_r4_addr_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_addr_n |=> lb_addr_n);

  a_r3_addr_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lb_addr_n) |-> $past(!lb_attn_n && lb_wait_n));

  a_r5_addr_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_addr_n |-> (lb_dq_oe && lb_xfer_n));

  a_r2_strobe_under_attn: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_xfer_n |-> !lb_attn_n);

  a_r6_turnaround_released: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!lb_addr_n) && !lb_write && lb_xfer_n) |-> !lb_dq_oe);

  a_r9_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_xfer_n && lb_write) |-> (lb_dq_oe && wr_next));

  a_r10_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_xfer_n && !lb_write) |-> !lb_dq_oe);

  a_r10_rdvalid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!lb_xfer_n && !lb_write));

  a_r11_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lb_attn_n && $past(!lb_xfer_n)));
endmodule

bind ptx_seq ptx_seq_chk u_chk (.*);

// File: tb/ptx_seq_tb.sv
module ptx_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [3:0]  req_be_n = 4'hF;
  logic        req_burst = 1'b0;
  logic [1:0]  req_region = '0;
  logic [7:0]  req_beats = '0;
  logic [15:0] region_cfg = '0;
  logic [31:0] wr_data = '0;
  logic        wr_next;
  logic [31:0] rd_data;
  logic        rd_valid, done;
  logic        lb_attn_n;
  logic        lb_wait_n = 1'b1;
  logic        lb_addr_n, lb_xfer_n, lb_write, lb_burst_n;
  logic [1:0]  lb_region;
  logic [3:0]  lb_be_n;
  logic [31:0] lb_dq_o;
  logic        lb_dq_oe;
  logic [31:0] lb_dq_i = '0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ptx_seq u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // {poke, write, en, ws[2:0], beats[7:0], burst, hold[2:0], region[1:0]}
  localparam logic [19:0] VEC [10] = '{
    {1'b0, 1'b0, 1'b1, 3'd0, 8'd4, 1'b1, 3'd0, 2'd1},
    {1'b0, 1'b1, 1'b1, 3'd0, 8'd3, 1'b1, 3'd2, 2'd0},
    {1'b0, 1'b0, 1'b0, 3'd0, 8'd1, 1'b0, 3'd1, 2'd3},
    {1'b0, 1'b1, 1'b0, 3'd0, 8'd4, 1'b1, 3'd0, 2'd2},
    {1'b0, 1'b0, 1'b1, 3'd2, 8'd3, 1'b1, 3'd0, 2'd2},
    {1'b0, 1'b1, 1'b1, 3'd3, 8'd2, 1'b1, 3'd1, 2'd3},
    {1'b1, 1'b0, 1'b0, 3'd1, 8'd5, 1'b1, 3'd3, 2'd0},
    {1'b0, 1'b1, 1'b0, 3'd7, 8'd2, 1'b1, 3'd0, 2'd1},
    {1'b0, 1'b0, 1'b1, 3'd0, 8'd0, 1'b1, 3'd0, 2'd0},
    {1'b1, 1'b1, 1'b1, 3'd0, 8'd5, 1'b0, 3'd4, 2'd2}
  };

  task automatic run_xfer(input int idx);
    logic [19:0] vv;
    bit poke, wr, en, bu;
    int ws, beats, hold, rg, v, first, nb, last, wi, rc, rdrv;
    bit prev_rx;
    logic [31:0] addr;
    logic [3:0] be;
    string ptag, otag;
    vv = VEC[idx];
    poke = vv[19]; wr = vv[18]; en = vv[17]; ws = int'(vv[16:14]);
    beats = int'(vv[13:6]); bu = vv[5]; hold = int'(vv[4:2]); rg = int'(vv[1:0]);
    addr = 32'hA000_0004 + 32'(idx * 16);
    be = 4'(idx * 3);
    v = 2 + hold;
    if (en) first = (ws == 0) ? (wr ? v + 1 : v + 2) : v + 1 + ws;
    else    first = v + ws;
    nb = (bu && beats != 0) ? beats : 1;
    last = first + (nb - 1) * (ws + 1);
    if (en) ptag = (ws == 0) ? (wr ? "R4" : "R6") : "R8";
    else    ptag = (ws == 0) ? "R7" : "R8";
    wi = 0; rc = 0; rdrv = 0; prev_rx = 1'b0;

    @(negedge clk);
    for (int r = 0; r < 4; r++)
      region_cfg[r*4 +: 4] = (r == rg) ? {en, 3'(ws)} : {~en, 3'd5};
    req_addr = addr; req_write = wr; req_be_n = be; req_burst = bu;
    req_region = 2'(rg); req_beats = 8'(beats); req_start = 1'b1;
    lb_wait_n = (0 >= 1 + hold);
    wr_data = 32'hD000_0000;
    lb_dq_i = 32'hE000_0000;

    for (int k = 1; k <= last + 2; k++) begin
      bit ex, ea, et, ed, eo;
      @(negedge clk);
      ex = (k >= first) && ((k - first) % (ws + 1) == 0) && ((k - first) / (ws + 1) < nb);
      ea = en && (k == v);
      et = (k >= 1) && (k <= last);
      ed = (k == last + 1);
      eo = ea || (ex && wr);
      otag = ea ? "R5" : (wr ? "R9" : ((en && ws == 0) ? "R6" : "R10"));
      chk(lb_attn_n == !et, "R2", 32'(lb_attn_n), 32'(!et));
      chk(lb_addr_n == !ea, "R4", 32'(lb_addr_n), 32'(!ea));
      if (k < v) chk(lb_xfer_n && lb_addr_n, "R3", {lb_addr_n, lb_xfer_n}, 32'h3);
      chk(lb_xfer_n == !ex, ptag, 32'(lb_xfer_n), 32'(!ex));
      chk(lb_dq_oe == eo, otag, 32'(lb_dq_oe), 32'(eo));
      if (ea) chk(lb_dq_o == addr, "R5", lb_dq_o, addr);
      if (ex && wr) begin
        chk(lb_dq_o == 32'hD000_0000 + 32'(wi) && wr_next, "R9", lb_dq_o, 32'hD000_0000 + 32'(wi));
        wi++;
        wr_data = 32'hD000_0000 + 32'(wi);
      end
      if (rd_valid) begin
        chk(!wr && rd_data == 32'hE000_0000 + 32'(rc), "R10", rd_data, 32'hE000_0000 + 32'(rc));
        rc++;
      end
      chk(done == ed, "R11", 32'(done), 32'(ed));
      if (et) chk({lb_write, lb_be_n, lb_region, lb_burst_n} == {wr, be, 2'(rg), !bu}, "R12",
                  32'({lb_write, lb_be_n, lb_region, lb_burst_n}), 32'({wr, be, 2'(rg), !bu}));
      if (prev_rx) rdrv++;
      prev_rx = !lb_xfer_n && !wr;
      lb_dq_i = 32'hE000_0000 + 32'(rdrv);
      lb_wait_n = (k >= 1 + hold);
      req_start = (poke && k == 2);
      if (poke && k == 2) req_addr = 32'h5555_0000;
    end
    chk(rc == (wr ? 0 : nb), "R10", 32'(rc), 32'(wr ? 0 : nb));
    chk(wi == (wr ? nb : 0), "R11", 32'(wi), 32'(wr ? nb : 0));
  endtask

  task automatic check_idle(input string tag);
    chk({lb_attn_n, lb_addr_n, lb_xfer_n, lb_burst_n} == 4'hF, tag,
        32'({lb_attn_n, lb_addr_n, lb_xfer_n, lb_burst_n}), 32'hF);
    chk(lb_be_n == 4'hF && !lb_dq_oe && !done && !rd_valid, tag,
        32'({lb_be_n, lb_dq_oe, done, rd_valid}), 32'h78);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    for (int i = 0; i < 10; i++) run_xfer(i);

    // R1: reset in the middle of a write burst returns the block to idle
    @(negedge clk);
    region_cfg = 16'h0000;
    req_write = 1'b1; req_burst = 1'b1; req_beats = 8'd6; req_region = 2'd0;
    req_be_n = 4'h0; req_start = 1'b1; lb_wait_n = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!lb_xfer_n, "R11", 32'(lb_xfer_n), 32'h0);
    rst_n = 1'b0;
    #1;
    check_idle("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1");

    // R3: attention held off by wait stays pending with no strobe
    req_write = 1'b0; req_burst = 1'b0; region_cfg = 16'h8888;
    lb_wait_n = 1'b0; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    repeat (5) begin
      @(negedge clk);
      chk(!lb_attn_n && lb_addr_n && lb_xfer_n, "R3", {lb_attn_n, lb_addr_n, lb_xfer_n}, 32'h3);
    end
    lb_wait_n = 1'b1;
    @(negedge clk);
    chk(!lb_addr_n, "R4", 32'(lb_addr_n), 32'h0);
    repeat (4) @(negedge clk);
    check_idle("R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule